// File: doc/BRIEF.md
# Multiplied Clock Correction Counter

This block turns a stream of external edge events into a corrected train of multiplied clock pulses. Everything runs on a single peripheral clock, and all inputs are synchronous enables. An edge counter keeps a running count of input edges. On each edge, that count, scaled by a power-of-two factor, is loaded into a target counter. Between edges the target counter steps on a raw multiplied tick that is generated elsewhere.

An output counter follows the target one step per clock and emits one corrected pulse per step. It never passes the target, so each input interval yields exactly the selected number of pulses once the train is in steady state. A programmable compare value can return all three counters to zero. When it does, the block emits a clear pulse for the free-running counters downstream.

When the start input is low, every counter is held at zero. After start rises, the first edge arms the block.

Top module: `mclk_corrector`

## Requirements
- R1: While start_i is low (or rst_n is low), edge_cnt_o, target_o and out_cnt_o are zero one clock later, and pulse_o and clr_o are low.
- R2: After start_i rises and before the first edge_i, tick_i has no effect; target_o stays zero.
- R3: On a clock with edge_i high, target_o becomes edge_cnt_o shifted left by mult_sel_i bits (factor 2^mult_sel_i, mult_sel_i = 3 gives 8, mult_sel_i = 5 gives 32), truncated to 16 bits. In the same clock, edge_cnt_o increments by one.
- R4: On a clock with tick_i high, no edge and the block armed, target_o increments by one. When edge_i and tick_i are both high, the edge load wins and the tick is dropped.
- R5: With halt_en_i = 1, a tick is ignored while target_o equals edge_cnt_o shifted by mult_sel_i. With halt_en_i = 0, the target keeps counting past that value.
- R6: When out_cnt_o is below target_o, out_cnt_o increments by one at the next clock. pulse_o is high in exactly the cycle in which the new value appears.
- R7: When out_cnt_o is at or above target_o, for example after a reload below it, out_cnt_o holds and pulse_o stays low.
- R8: When the block is armed, clr_val_i is nonzero and out_cnt_o equals clr_val_i, all three counters read zero one clock later and clr_o is high for that single cycle. A clr_val_i of zero disables the clear.
- R9: With halt_en_i = 1 and at least 2^mult_sel_i ticks per edge interval, each interval yields exactly 2^mult_sel_i corrected pulses.
- R10: With factor 32, the loads after edge counts 0, 1, 2, 3 are 0x0000, 0x0020, 0x0040, 0x0060.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Run enable; low holds all counters at zero |
| edge_i | input | 1 | External edge event, one-clock pulse |
| tick_i | input | 1 | Raw multiplied tick, one-clock pulse |
| mult_sel_i | input | 3 | Factor select, factor = 2^mult_sel_i |
| halt_en_i | input | 1 | 1: target stops at scaled edge count |
| clr_val_i | input | 16 | Clear compare value for the output counter; 0 disables |
| pulse_o | output | 1 | Corrected multiplied clock pulse |
| clr_o | output | 1 | Clear pulse for downstream counters |
| edge_cnt_o | output | 16 | Edge counter value |
| target_o | output | 16 | Target counter value |
| out_cnt_o | output | 16 | Output counter value |

## Verification
The case that is hardest to reach from the ports is an output counter that sits above a freshly reloaded target. It needs a run with halt disabled, so that the target overshoots. The output counter must then catch up, and only after that does an edge arrive with a smaller factor. The stimulus builds this in steps: several factor-32 intervals with halt on, one long interval with halt off, idle time so the output counter catches up, and then an edge with factor 8. A later sequence drives an edge and a tick in the same cycle. After a restart, it runs the output counter into a small compare value, so that the clear fires in the middle of an interval.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

   typedef enum logic [1:0] {
      TGT_HOLD = 2'd0,
      TGT_LOAD = 2'd1,
      TGT_STEP = 2'd2,
      TGT_ZERO = 2'd3
   } tgt_op_e;

   typedef struct packed {
      logic run;
      logic clear;
      logic load;
      logic armed;
   } mcc_ctl_t;

endpackage

// File: rtl/mcc_barrel_shift.sv
module mcc_barrel_shift #(
   parameter int W  = 16,
   parameter int SW = 3
) (
   input  logic [W-1:0]  data_i,
   input  logic [SW-1:0] sel_i,
   output logic [W-1:0]  data_o
);
   logic [W-1:0] stage [SW+1];

   assign stage[0] = data_i;

   for (genvar i = 0; i < SW; i++) begin : g_stage
      localparam int AMT = 2 ** i;
      if (AMT >= W) begin : g_wide
         assign stage[i+1] = sel_i[i] ? '0 : stage[i];
      end else begin : g_narrow
         assign stage[i+1] = sel_i[i] ? {stage[i][W-1-AMT:0], {AMT{1'b0}}} : stage[i];
      end
   end

   assign data_o = stage[SW];
endmodule

// File: rtl/mcc_edge_counter.sv
module mcc_edge_counter
   import mcc_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  mcc_ctl_t     ctl_i,
   input  logic         edge_i,
   output logic [W-1:0] cnt_o,
   output logic         armed_o
);
   logic [W-1:0] cnt_q;
   logic         armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !ctl_i.run) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (ctl_i.clear) begin
         cnt_q   <= '0;
      end else if (edge_i) begin
         cnt_q   <= cnt_q + 1'b1;
         armed_q <= 1'b1;
      end
   end

   assign cnt_o   = cnt_q;
   assign armed_o = armed_q;
endmodule

// File: rtl/mcc_target_counter.sv
module mcc_target_counter
   import mcc_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  mcc_ctl_t     ctl_i,
   input  logic         tick_i,
   input  logic         halt_en_i,
   input  logic [W-1:0] scaled_i,
   output logic [W-1:0] tgt_o
);
   logic [W-1:0] tgt_q;
   tgt_op_e      op;
   logic         at_limit;

   assign at_limit = halt_en_i && (tgt_q == scaled_i);

   always_comb begin
      if (!ctl_i.run || ctl_i.clear)            op = TGT_ZERO;
      else if (ctl_i.load)                      op = TGT_LOAD;
      else if (ctl_i.armed && tick_i && !at_limit) op = TGT_STEP;
      else                                      op = TGT_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_q <= '0;
      end else begin
         case (op)
            TGT_ZERO: tgt_q <= '0;
            TGT_LOAD: tgt_q <= scaled_i;
            TGT_STEP: tgt_q <= tgt_q + 1'b1;
            default:  tgt_q <= tgt_q;
         endcase
      end
   end

   assign tgt_o = tgt_q;
endmodule

// File: rtl/mcc_chase_counter.sv
module mcc_chase_counter
   import mcc_pkg::*;
#(
   parameter int W         = 16,
   parameter bit HAS_CLEAR = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic         armed_i,
   input  logic [W-1:0] tgt_i,
   input  logic [W-1:0] clr_val_i,
   output logic         hit_o,
   output logic [W-1:0] cnt_o,
   output logic         pulse_o,
   output logic         clr_o
);
   logic [W-1:0] cnt_q;
   logic         pulse_q;
   logic         clr_q;
   logic         behind;

   if (HAS_CLEAR) begin : g_clear
      assign hit_o = run_i && armed_i && (clr_val_i != '0) && (cnt_q == clr_val_i);
   end else begin : g_noclear
      logic unused_clr;
      assign unused_clr = ^clr_val_i;
      assign hit_o      = 1'b0;
   end

   assign behind = cnt_q < tgt_i;

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i) begin
         cnt_q   <= '0;
         pulse_q <= 1'b0;
         clr_q   <= 1'b0;
      end else if (hit_o) begin
         cnt_q   <= '0;
         pulse_q <= 1'b0;
         clr_q   <= 1'b1;
      end else begin
         clr_q   <= 1'b0;
         pulse_q <= behind;
         if (behind) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o   = cnt_q;
   assign pulse_o = pulse_q;
   assign clr_o   = clr_q;
endmodule

// File: rtl/mclk_corrector.sv
module mclk_corrector
   import mcc_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int SEL_W     = 3,
   parameter bit HAS_CLEAR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             edge_i,
   input  logic             tick_i,
   input  logic [SEL_W-1:0] mult_sel_i,
   input  logic             halt_en_i,
   input  logic [CNT_W-1:0] clr_val_i,
   output logic             pulse_o,
   output logic             clr_o,
   output logic [CNT_W-1:0] edge_cnt_o,
   output logic [CNT_W-1:0] target_o,
   output logic [CNT_W-1:0] out_cnt_o
);
   localparam int MAX_SHIFT = (2 ** SEL_W) - 1;

   if (CNT_W < 4) begin : g_bad_width
      $error("CNT_W must be at least 4");
   end
   if (SEL_W < 1 || SEL_W > 5) begin : g_bad_sel
      $error("SEL_W must be in 1..5");
   end
   if (MAX_SHIFT >= 2 * CNT_W) begin : g_bad_shift
      $error("factor range too large for counter width");
   end

   mcc_ctl_t         ctl;
   logic             armed;
   logic             hit;
   logic [CNT_W-1:0] d_cnt;
   logic [CNT_W-1:0] scaled;
   logic [CNT_W-1:0] tgt;

   assign ctl.run   = start_i;
   assign ctl.clear = hit;
   assign ctl.load  = start_i && edge_i && !hit;
   assign ctl.armed = armed;

   mcc_edge_counter #(.W(CNT_W)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_i   (ctl),
      .edge_i  (edge_i),
      .cnt_o   (d_cnt),
      .armed_o (armed)
   );

   mcc_barrel_shift #(.W(CNT_W), .SW(SEL_W)) u_shift (
      .data_i (d_cnt),
      .sel_i  (mult_sel_i),
      .data_o (scaled)
   );

   mcc_target_counter #(.W(CNT_W)) u_tgt (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_i     (ctl),
      .tick_i    (tick_i),
      .halt_en_i (halt_en_i),
      .scaled_i  (scaled),
      .tgt_o     (tgt)
   );

   mcc_chase_counter #(.W(CNT_W), .HAS_CLEAR(HAS_CLEAR)) u_chase (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (start_i),
      .armed_i   (armed),
      .tgt_i     (tgt),
      .clr_val_i (clr_val_i),
      .hit_o     (hit),
      .cnt_o     (out_cnt_o),
      .pulse_o   (pulse_o),
      .clr_o     (clr_o)
   );

   assign edge_cnt_o = d_cnt;
   assign target_o   = tgt;
endmodule

// File: rtl/mcc_checker.sv
module mcc_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             edge_i,
   input logic             pulse_o,
   input logic             clr_o,
   input logic [CNT_W-1:0] edge_cnt_o,
   input logic [CNT_W-1:0] target_o,
   input logic [CNT_W-1:0] out_cnt_o
);
   assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> (edge_cnt_o == '0 && target_o == '0 && out_cnt_o == '0 && !pulse_o && !clr_o));

   assert_edge_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(start_i && edge_i) && !clr_o) |-> edge_cnt_o == CNT_W'($past(edge_cnt_o) + 1'b1));

   assert_pulse_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |-> out_cnt_o == CNT_W'($past(out_cnt_o) + 1'b1));

   assert_pulse_when_behind_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(start_i) && !clr_o && $past(out_cnt_o < target_o)) |-> pulse_o);

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(start_i) && !pulse_o && !clr_o) |-> $stable(out_cnt_o));

   assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_o |-> (edge_cnt_o == '0 && target_o == '0 && out_cnt_o == '0 && !pulse_o));

   assert_clear_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_o |=> !clr_o);
endmodule

bind mclk_corrector mcc_checker #(.CNT_W(CNT_W)) u_mcc_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .edge_i     (edge_i),
   .pulse_o    (pulse_o),
   .clr_o      (clr_o),
   .edge_cnt_o (edge_cnt_o),
   .target_o   (target_o),
   .out_cnt_o  (out_cnt_o)
);

// File: tb/mclk_corrector_tb_top.sv
`timescale 1ns/1ps
module mclk_corrector_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        edge_i = 1'b0;
   logic        tick_i = 1'b0;
   logic [2:0]  mult_sel_i = 3'd0;
   logic        halt_en_i = 1'b0;
   logic [15:0] clr_val_i = 16'd0;
   logic        pulse_o, clr_o;
   logic [15:0] edge_cnt_o, target_o, out_cnt_o;

   int checks = 0;
   int errors = 0;
   int pcount = 0;
   int clr_seen = 0;
   bit done = 1'b0;

   int md = 0, mt = 0, mf = 0, mp = 0, mc = 0;
   bit marm = 1'b0;

   always #2 clk = ~clk;

   mclk_corrector dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .edge_i(edge_i), .tick_i(tick_i),
      .mult_sel_i(mult_sel_i), .halt_en_i(halt_en_i), .clr_val_i(clr_val_i),
      .pulse_o(pulse_o), .clr_o(clr_o), .edge_cnt_o(edge_cnt_o),
      .target_o(target_o), .out_cnt_o(out_cnt_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural reference, updated on every rising edge
   always @(posedge clk) begin
      int nt, scl;
      if (!rst_n || !start_i) begin
         md = 0; mt = 0; mf = 0; mp = 0; mc = 0; marm = 1'b0;
      end else if (marm && clr_val_i != 0 && mf == int'(clr_val_i)) begin
         md = 0; mt = 0; mf = 0; mp = 0; mc = 1;
      end else begin
         mc  = 0;
         scl = (md << mult_sel_i) & 16'hFFFF;
         nt  = mt;
         if (edge_i) nt = scl;
         else if (marm && tick_i && !(halt_en_i && mt == scl)) nt = (mt + 1) & 16'hFFFF;
         if (mf < mt) begin mf = mf + 1; mp = 1; end
         else mp = 0;
         if (edge_i) begin md = (md + 1) & 16'hFFFF; marm = 1'b1; end
         mt = nt;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         chk("R3 edge counter", int'(edge_cnt_o), md);
         chk("R4 target counter", int'(target_o), mt);
         chk("R6 output counter", int'(out_cnt_o), mf);
         chk("R6 pulse", int'(pulse_o), mp);
         chk("R8 clear pulse", int'(clr_o), mc);
      end
   end

   task automatic cyc(input bit e, input bit t);
      edge_i = e;
      tick_i = t;
      @(negedge clk);
      #1;
      pcount   += int'(pulse_o);
      clr_seen += int'(clr_o);
      edge_i = 1'b0;
      tick_i = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         cyc(1'b0, 1'b1);
         cyc(1'b0, 1'b0);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0);
   endtask

   task automatic summary;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      @(negedge clk); #1;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1: reset and idle state
      chk("R1 idle edge", int'(edge_cnt_o), 0);
      chk("R1 idle target", int'(target_o), 0);
      chk("R1 idle out", int'(out_cnt_o), 0);
      chk("R1 idle pulse", int'(pulse_o), 0);

      // R2: ticks before the first edge are ignored
      start_i = 1'b1;
      ticks(10);
      chk("R2 target before edge", int'(target_o), 0);
      chk("R2 out before edge", int'(out_cnt_o), 0);

      // R10 / R9 / R5: factor 32, halt on
      mult_sel_i = 3'd5;
      halt_en_i  = 1'b1;
      for (int k = 0; k < 4; k++) begin
         cyc(1'b1, 1'b0);
         chk("R10 load value", int'(target_o), k * 32);
         chk("R3 edge increment", int'(edge_cnt_o), k + 1);
         pcount = 0;
         ticks(40);
         chk("R5 halted target", int'(target_o), (k + 1) * 32);
         idle(20);
         chk("R9 pulses per interval", pcount, 32);
      end

      // R5: halt off, target runs past the scaled value
      halt_en_i = 1'b0;
      cyc(1'b1, 1'b0);
      chk("R3 load 4x32", int'(target_o), 128);
      ticks(40);
      chk("R5 free-running target", int'(target_o), 168);
      idle(60);
      chk("R6 out caught up", int'(out_cnt_o), 168);

      // R7: reload below the output counter
      mult_sel_i = 3'd3;
      cyc(1'b1, 1'b0);
      chk("R3 load 5x8", int'(target_o), 40);
      pcount = 0;
      idle(5);
      chk("R7 out holds", int'(out_cnt_o), 168);
      chk("R7 no pulses", pcount, 0);

      // R4: edge and tick together, edge wins
      cyc(1'b1, 1'b1);
      chk("R4 edge priority", int'(target_o), 48);
      chk("R4 edge count", int'(edge_cnt_o), 7);
      chk("R8 disabled clear", clr_seen, 0);

      // R1: start low clears everything
      start_i = 1'b0;
      cyc(1'b0, 1'b0);
      chk("R1 stop edge", int'(edge_cnt_o), 0);
      chk("R1 stop target", int'(target_o), 0);
      chk("R1 stop out", int'(out_cnt_o), 0);

      // R8: clear compare fires mid interval
      clr_val_i  = 16'd20;
      mult_sel_i = 3'd4;
      halt_en_i  = 1'b1;
      start_i    = 1'b1;
      cyc(1'b1, 1'b0);
      ticks(16);
      idle(10);
      chk("R5 target at 16", int'(target_o), 16);
      cyc(1'b1, 1'b0);
      ticks(16);
      idle(10);
      chk("R8 clear once", clr_seen, 1);
      chk("R8 edge after clear", int'(edge_cnt_o), 0);
      chk("R8 target after clear", int'(target_o), 0);
      chk("R8 out after clear", int'(out_cnt_o), 0);

      idle(2);
      summary();
   end
endmodule